// File: doc/BRIEF.md
# SPI Channel Transfer Controller

This block is one channel of a multichannel SPI master. It holds the channel's configuration, transmit word, receive word, a three-flag status and an enable bit, and it decides when a word transfer may start. A transfer is attempted when the host writes the transmit register, when it reads the receive register, and when the channel enable goes from 0 to 1. Whether an attempt starts depends on the transfer mode (full-duplex, receive-only or transmit-only), a turbo option that lets a new word start while the previous received word is still unread, and the current status.

The channel shifts a word of programmable length (4 to 32 bits) MSB-first on the bus using a serial clock divided from the system clock. When the surrounding module runs in single-channel mode, the bus is driven only if the channel's force bit is set. Otherwise the status still advances as if a word had been moved. Level outputs toward an interrupt collector and toward two DMA request lines follow from the status, the mode and the configuration.

Top module: `spi_chan_ctrl`

## Requirements
- R1: After reset the status reads 3'b010 (bit 0 receive-full = 0, bit 1 transmit-empty = 1, bit 2 end-of-transfer = 0), the configuration reads 0x060000, the enable reads 0, `cs_n_o` is 1, `sclk_o` is 0 and both DMA requests are 0.
- R2: A write with `wr_sel_i`=0 stores bits [22:0] of the data as configuration. Bits above 22 are dropped. Reading with `rd_sel_i`=0 returns the stored value zero-extended.
- R3: A write with `wr_sel_i`=2 loads the transmit word, clears transmit-empty and makes a start attempt. A read with `rd_sel_i`=3 returns the receive word one cycle later, clears receive-full and makes a start attempt. A read with `rd_sel_i`=2 returns the transmit word, and a read with `rd_sel_i`=1 returns {enable, status} in bits [3:0].
- R4: A write with `wr_sel_i`=1 sets the enable to data bit 0. No transfer starts while the enable is 0. A 0-to-1 change of the enable makes a start attempt.
- R5: The mode is config [13:12]: 0 is full-duplex, 1 is receive-only, 2 is transmit-only, and 3 acts as full-duplex. An attempt is blocked while receive-full is set, unless the mode is transmit-only or turbo (config bit 19) is 1. An attempt is also blocked while transmit-empty is set, unless the mode is receive-only. An attempt made while a word is shifting waits until the word ends.
- R6: When a transfer ends, end-of-transfer and transmit-empty are set and the transmit word becomes 0. Receive-full is also set unless the mode is transmit-only. End-of-transfer stays set until reset.
- R7: The word length is config [11:7] plus 1, and field values below 3 give 4 bits. `cs_n_o` is low for the whole word. `sclk_o` idles low with a half period of CLK_DIV cycles and shows exactly one rising edge per bit. `mosi_o` carries the transmit word MSB-first and changes after falling edges. `miso_i` is sampled on rising edges, and the receive word holds the sampled bits right-aligned with the upper bits 0.
- R8: With `single_mode_i`=1 and force (config bit 20) at 0, a started transfer produces no bus activity and leaves the receive word unchanged, but the status advances as in R6. With force at 1 the word is shifted normally.
- R9: The transmit DMA request is enable AND config bit 14 AND transmit-empty AND mode not receive-only. The receive DMA request is enable AND config bit 15 AND receive-full AND mode not transmit-only.
- R10: `tx_empty_evt_o` is transmit-empty AND mode not receive-only. `rx_full_evt_o` is receive-full AND mode not transmit-only AND turbo is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| single_mode_i | input | 1 | Module runs in single-channel mode |
| wr_en_i | input | 1 | Host write strobe |
| wr_sel_i | input | 2 | Write target: 0 config, 1 enable, 2 transmit word |
| wr_data_i | input | DATA_W | Host write data |
| rd_en_i | input | 1 | Host read strobe |
| rd_sel_i | input | 2 | Read source: 0 config, 1 enable/status, 2 transmit, 3 receive |
| rd_data_o | output | DATA_W | Read data, valid the cycle after the strobe |
| status_o | output | 3 | Live status flags {end, tx-empty, rx-full} |
| miso_i | input | 1 | Serial data from the slave |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the slave |
| cs_n_o | output | 1 | Active-low chip select |
| dma_tx_req_o | output | 1 | Transmit DMA request level |
| dma_rx_req_o | output | 1 | Receive DMA request level |
| tx_empty_evt_o | output | 1 | Transmit-empty event level |
| rx_full_evt_o | output | 1 | Receive-full event level |

## Verification
Some rules hold at every cycle, and the assertions check them there. Chip select stays low exactly while a word shifts, and the bus is quiet otherwise. A word never starts with the channel disabled. A transmit write always clears transmit-empty in the next cycle. End-of-transfer is set whenever a word finishes. Each request or event level is backed by its status flag. Other behaviour only shows up in the bench scenarios: the gating of start attempts by mode and turbo, the bit order and bit count on the wire, the received data for loopback and inverted slaves, word-length clamping, and the single-channel bypass that leaves the receive word untouched.

// File: rtl/spi_chan_pkg.sv
// spi_chan_pkg: shared constants, select codes and helper functions for the
// SPI channel controller. Assumes a 23-bit configuration register layout.
package spi_chan_pkg;

    localparam int CFG_W      = 23;
    localparam int WL_LSB     = 7;
    localparam int WL_FLD_W   = 5;
    localparam int MODE_LSB   = 12;
    localparam int DMA_TX_BIT = 14;
    localparam int DMA_RX_BIT = 15;
    localparam int TURBO_BIT  = 19;
    localparam int FORCE_BIT  = 20;

    localparam int ST_RXF = 0;
    localparam int ST_TXE = 1;
    localparam int ST_EOT = 2;

    localparam logic [CFG_W-1:0] CFG_RESET = 23'h060000;
    localparam logic [2:0]       ST_RESET  = 3'b010;

    typedef enum logic [1:0] {
        MODE_DUPLEX  = 2'd0,
        MODE_RX_ONLY = 2'd1,
        MODE_TX_ONLY = 2'd2,
        MODE_ALT     = 2'd3
    } xfer_mode_e;

    localparam logic [1:0] WR_CFG = 2'd0;
    localparam logic [1:0] WR_EN  = 2'd1;
    localparam logic [1:0] WR_TX  = 2'd2;

    localparam logic [1:0] RD_CFG  = 2'd0;
    localparam logic [1:0] RD_STAT = 2'd1;
    localparam logic [1:0] RD_TX   = 2'd2;
    localparam logic [1:0] RD_RX   = 2'd3;

    // Convert the word-length field into a bit count, clamping illegal values.
    function automatic logic [5:0] word_len(input logic [WL_FLD_W-1:0] fld);
        if (fld < 5'd3) return 6'd4;
        return {1'b0, fld} + 6'd1;
    endfunction

    // Extract the transfer mode from a configuration word.
    function automatic xfer_mode_e cfg_mode(input logic [CFG_W-1:0] cfg);
        return xfer_mode_e'(cfg[MODE_LSB +: 2]);
    endfunction

endpackage

// File: rtl/spi_chan_regs.sv
// spi_chan_regs: channel registers and transfer sequencing. Holds config,
// transmit/receive words, status and enable; turns host accesses into start
// attempts and applies the end-of-transfer update.
// Assumes: the shifter reports done while still busy, and only one transfer
// can be in flight.
module spi_chan_regs
    import spi_chan_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int WL_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              single_mode,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic              shift_busy,
    input  logic              shift_done,
    input  logic [DATA_W-1:0] shift_rx_word,
    output logic              shift_start,
    output logic [DATA_W-1:0] shift_tx_word,
    output logic [WL_W-1:0]   shift_wl,
    output logic [CFG_W-1:0]  cfg_q,
    output logic [2:0]        st_q,
    output logic              en_q
);

    logic [DATA_W-1:0] tx_q;
    logic [DATA_W-1:0] rx_q;
    logic              try_q;
    xfer_mode_e        mode;
    logic              turbo;
    logic              force_shift;
    logic              ev_tx_wr;
    logic              ev_rx_rd;
    logic              ev_en_rise;
    logic              rx_block;
    logic              tx_block;
    logic              start_ok;
    logic              bypass_done;
    logic              complete;
    logic [DATA_W-1:0] rd_mux;

    // Decode configuration fields used by the sequencer.
    always_comb begin
        mode        = cfg_mode(cfg_q);
        turbo       = cfg_q[TURBO_BIT];
        force_shift = cfg_q[FORCE_BIT];
        shift_wl    = WL_W'(word_len(cfg_q[WL_LSB +: WL_FLD_W]));
    end

    // Identify host accesses that produce a start attempt.
    always_comb begin
        ev_tx_wr   = wr_en && (wr_sel == WR_TX);
        ev_rx_rd   = rd_en && (rd_sel == RD_RX);
        ev_en_rise = wr_en && (wr_sel == WR_EN) && wr_data[0] && !en_q;
    end

    // Decide whether a pending attempt may start now and how it completes.
    always_comb begin
        rx_block    = st_q[ST_RXF] && (mode != MODE_TX_ONLY) && !turbo;
        tx_block    = st_q[ST_TXE] && (mode != MODE_RX_ONLY);
        start_ok    = try_q && en_q && !shift_busy && !rx_block && !tx_block;
        bypass_done = start_ok && single_mode && !force_shift;
        shift_start = start_ok && !(single_mode && !force_shift);
        complete    = bypass_done || shift_done;
        shift_tx_word = tx_q;
    end

    // Hold a start attempt while a word is shifting, drop it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) try_q <= 1'b0;
        else        try_q <= ev_tx_wr || ev_rx_rd || ev_en_rise || (try_q && shift_busy);
    end

    // Configuration register keeps only its defined bits.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cfg_q <= CFG_RESET;
        else if (wr_en && wr_sel == WR_CFG)  cfg_q <= wr_data[CFG_W-1:0];
    end

    // Channel enable follows data bit 0 on an enable write.
    always_ff @(posedge clk) begin
        if (!rst_n)                         en_q <= 1'b0;
        else if (wr_en && wr_sel == WR_EN)  en_q <= wr_data[0];
    end

    // Status and data words: read clears, completion sets, host write wins last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_RESET;
            tx_q <= '0;
            rx_q <= '0;
        end else begin
            if (ev_rx_rd) st_q[ST_RXF] <= 1'b0;
            if (complete) begin
                st_q[ST_EOT] <= 1'b1;
                st_q[ST_TXE] <= 1'b1;
                tx_q         <= '0;
                if (mode != MODE_TX_ONLY) st_q[ST_RXF] <= 1'b1;
                if (shift_done)           rx_q         <= shift_rx_word;
            end
            if (ev_tx_wr) begin
                tx_q         <= wr_data;
                st_q[ST_TXE] <= 1'b0;
            end
        end
    end

    // Select the register seen by the host read port.
    always_comb begin
        unique case (rd_sel)
            RD_CFG:  rd_mux = DATA_W'(cfg_q);
            RD_STAT: rd_mux = DATA_W'({en_q, st_q});
            RD_TX:   rd_mux = tx_q;
            default: rd_mux = rx_q;
        endcase
    end

    // Register read data one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
    end

endmodule

// File: rtl/spi_chan_shifter.sv
// spi_chan_shifter: serial engine for one word. Drives MSB-first on mosi,
// samples miso on the rising serial clock edge, shifts after the falling edge.
// Assumes: start is only raised while idle; wl is between 1 and DATA_W.
module spi_chan_shifter #(
    parameter int DATA_W  = 32,
    parameter int WL_W    = 6,
    parameter int CLK_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_word,
    input  logic [WL_W-1:0]   wl,
    input  logic              miso,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_word,
    output logic              sclk,
    output logic              mosi,
    output logic              cs_n
);

    localparam int DIV_W = $clog2(CLK_DIV) + 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

    logic              busy_q;
    logic              sclk_q;
    logic [DATA_W-1:0] sh_q;
    logic [DATA_W-1:0] rx_q;
    logic [WL_W-1:0]   bit_q;
    logic [WL_W-1:0]   wl_q;
    logic [DIV_W-1:0]  div_q;
    logic              tick;
    logic              last_bit;

    // Half-period tick and final-bit detection.
    always_comb begin
        tick     = busy_q && (div_q == DIV_LAST);
        last_bit = (bit_q == (wl_q - 1'b1));
        done     = tick && sclk_q && last_bit;
    end

    // Word sequencing: load on start, toggle clock on ticks, sample and shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            sclk_q <= 1'b0;
            sh_q   <= '0;
            rx_q   <= '0;
            bit_q  <= '0;
            wl_q   <= '0;
            div_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            sclk_q <= 1'b0;
            sh_q   <= tx_word << (DATA_W - int'(wl));
            rx_q   <= '0;
            bit_q  <= '0;
            wl_q   <= wl;
            div_q  <= '0;
        end else if (busy_q) begin
            div_q <= tick ? '0 : div_q + 1'b1;
            if (tick) begin
                sclk_q <= !sclk_q;
                if (!sclk_q) begin
                    rx_q <= {rx_q[DATA_W-2:0], miso};
                end else begin
                    sh_q  <= sh_q << 1;
                    bit_q <= bit_q + 1'b1;
                    if (last_bit) busy_q <= 1'b0;
                end
            end
        end
    end

    // Bus outputs: select low and data valid only while a word is in flight.
    always_comb begin
        busy    = busy_q;
        rx_word = rx_q;
        sclk    = sclk_q;
        cs_n    = !busy_q;
        mosi    = busy_q ? sh_q[DATA_W-1] : 1'b0;
    end

endmodule

// File: rtl/spi_chan_req.sv
// spi_chan_req: DMA request and event levels derived from enable, status,
// mode and configuration. Purely combinational; assumes registered inputs.
module spi_chan_req
    import spi_chan_pkg::*;
(
    input  logic             en,
    input  logic [CFG_W-1:0] cfg,
    input  logic [2:0]       st,
    output logic             dma_tx_req,
    output logic             dma_rx_req,
    output logic             tx_evt,
    output logic             rx_evt
);

    xfer_mode_e mode;
    logic       tx_side;
    logic       rx_side;

    // Which directions the current mode services.
    always_comb begin
        mode    = cfg_mode(cfg);
        tx_side = (mode != MODE_RX_ONLY);
        rx_side = (mode != MODE_TX_ONLY);
    end

    // Request and event levels.
    always_comb begin
        dma_tx_req = en && cfg[DMA_TX_BIT] && st[ST_TXE] && tx_side;
        dma_rx_req = en && cfg[DMA_RX_BIT] && st[ST_RXF] && rx_side;
        tx_evt     = st[ST_TXE] && tx_side;
        rx_evt     = st[ST_RXF] && rx_side && !cfg[TURBO_BIT];
    end

endmodule

// File: rtl/spi_chan_ctrl.sv
// spi_chan_ctrl: one SPI master channel. Connects the register/sequencer,
// the serial shifter and the request logic. Assumes a single host port and
// that the module-level single-channel flag arrives as a stable level.
module spi_chan_ctrl
    import spi_chan_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int CLK_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              single_mode_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_sel_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    input  logic [1:0]        rd_sel_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [2:0]        status_o,
    input  logic              miso_i,
    output logic              sclk_o,
    output logic              mosi_o,
    output logic              cs_n_o,
    output logic              dma_tx_req_o,
    output logic              dma_rx_req_o,
    output logic              tx_empty_evt_o,
    output logic              rx_full_evt_o
);

    localparam int WL_W = $clog2(DATA_W) + 1;

    logic [CFG_W-1:0]  cfg_w;
    logic [2:0]        st_w;
    logic              en_w;
    logic              start_w;
    logic [DATA_W-1:0] tx_word_w;
    logic [WL_W-1:0]   wl_w;
    logic              busy_w;
    logic              done_w;
    logic [DATA_W-1:0] rx_word_w;

    spi_chan_regs #(.DATA_W(DATA_W), .WL_W(WL_W)) regs_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .single_mode   (single_mode_i),
        .wr_en         (wr_en_i),
        .wr_sel        (wr_sel_i),
        .wr_data       (wr_data_i),
        .rd_en         (rd_en_i),
        .rd_sel        (rd_sel_i),
        .rd_data       (rd_data_o),
        .shift_busy    (busy_w),
        .shift_done    (done_w),
        .shift_rx_word (rx_word_w),
        .shift_start   (start_w),
        .shift_tx_word (tx_word_w),
        .shift_wl      (wl_w),
        .cfg_q         (cfg_w),
        .st_q          (st_w),
        .en_q          (en_w)
    );

    spi_chan_shifter #(.DATA_W(DATA_W), .WL_W(WL_W), .CLK_DIV(CLK_DIV)) shift_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_w),
        .tx_word (tx_word_w),
        .wl      (wl_w),
        .miso    (miso_i),
        .busy    (busy_w),
        .done    (done_w),
        .rx_word (rx_word_w),
        .sclk    (sclk_o),
        .mosi    (mosi_o),
        .cs_n    (cs_n_o)
    );

    spi_chan_req req_i (
        .en         (en_w),
        .cfg        (cfg_w),
        .st         (st_w),
        .dma_tx_req (dma_tx_req_o),
        .dma_rx_req (dma_rx_req_o),
        .tx_evt     (tx_empty_evt_o),
        .rx_evt     (rx_full_evt_o)
    );

    // Live status to the port.
    always_comb status_o = st_w;

endmodule

// File: rtl/spi_chan_ctrl_chk.sv
// spi_chan_ctrl_chk: temporal checks on the channel, bound into spi_chan_ctrl.
module spi_chan_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [1:0] wr_sel,
    input logic [2:0] status,
    input logic       en,
    input logic       busy,
    input logic       cs_n,
    input logic       sclk,
    input logic       dma_tx,
    input logic       dma_rx,
    input logic       rx_evt
);

    a_r3_tx_write_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd2) |=> !status[1]);

    a_r4_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(en));

    a_r7_select_covers_word: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !cs_n);

    a_r7_idle_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_n && !sclk));

    a_r6_end_flag_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> status[2]);

    a_r6_empty_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(wr_en && wr_sel == 2'd2)) |-> status[1]);

    a_r9_tx_req_backed: assert property (@(posedge clk) disable iff (!rst_n)
        dma_tx |-> (status[1] && en));

    a_r9_rx_req_backed: assert property (@(posedge clk) disable iff (!rst_n)
        dma_rx |-> (status[0] && en));

    a_r10_rx_evt_backed: assert property (@(posedge clk) disable iff (!rst_n)
        rx_evt |-> status[0]);

endmodule

bind spi_chan_ctrl spi_chan_ctrl_chk chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en_i),
    .wr_sel (wr_sel_i),
    .status (status_o),
    .en     (en_w),
    .busy   (busy_w),
    .cs_n   (cs_n_o),
    .sclk   (sclk_o),
    .dma_tx (dma_tx_req_o),
    .dma_rx (dma_rx_req_o),
    .rx_evt (rx_full_evt_o)
);

// File: tb/spi_chan_ctrl_tb_top.sv
module spi_chan_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        single_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_sel = 2'd0;
    logic [31:0] rd_data;
    logic [2:0]  status;
    logic        miso;
    logic        sclk, mosi, cs_n;
    logic        dma_tx, dma_rx, tx_evt, rx_evt;
    logic        inv = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    int rises = 0;
    int cs_falls = 0;
    logic [31:0] cap = '0;

    always #5 clk = !clk;

    assign miso = inv ? !mosi : mosi;

    spi_chan_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .single_mode_i(single_mode),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .rd_en_i(rd_en), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
        .status_o(status), .miso_i(miso), .sclk_o(sclk), .mosi_o(mosi),
        .cs_n_o(cs_n), .dma_tx_req_o(dma_tx), .dma_rx_req_o(dma_rx),
        .tx_empty_evt_o(tx_evt), .rx_full_evt_o(rx_evt)
    );

    always @(posedge sclk) begin
        cap   <= {cap[30:0], mosi};
        rises <= rises + 1;
    end

    always @(negedge cs_n) cs_falls <= cs_falls + 1;

    function automatic int wlen(input int fld);
        return (fld < 3) ? 4 : fld + 1;
    endfunction

    function automatic logic [31:0] wmask(input int wl);
        return (wl >= 32) ? 32'hFFFF_FFFF : ((32'd1 << wl) - 32'd1);
    endfunction

    function automatic logic [31:0] exp_rx(input logic [31:0] tx, input int fld, input logic iv);
        return (iv ? ~tx : tx) & wmask(wlen(fld));
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_sel = sel;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
        while (!cs_n) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        int r0, c0;
        void'($urandom(32'd7));

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, v); check("R1 config", v, 32'h060000);
        rd(2'd1, v); check("R1 status", v, 32'h2);
        check("R1 bus", {30'd0, cs_n, sclk}, 32'h2);
        check("R1 dma", {30'd0, dma_tx, dma_rx}, 32'h0);

        // R2 config width
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, v); check("R2 config mask", v, 32'h7F_FFFF);

        // R4 disabled: write tx, nothing starts
        wr(2'd0, 32'd7 << 7);
        c0 = cs_falls;
        wr(2'd2, 32'hA5);
        repeat (20) @(negedge clk);
        check("R4 no start while disabled", cs_falls - c0, 0);
        rd(2'd1, v); check("R3 tx write clears empty", v, 32'h0);
        r0 = rises;
        wr(2'd1, 32'd1);
        settle();
        check("R4 enable rise starts", cs_falls - c0, 1);
        check("R7 bit count", rises - r0, 8);
        check("R7 msb first", cap & 32'hFF, 32'hA5);
        rd(2'd1, v); check("R6 status after word", v, 32'hF);
        rd(2'd2, v); check("R6 tx zeroed", v, 32'h0);
        rd(2'd3, v); check("R7 loopback rx", v, 32'hA5);
        rd(2'd1, v); check("R3 rx read clears full", v, 32'hE);

        // R5 full-duplex blocked by unread rx
        wr(2'd2, 32'h3C); settle();
        c0 = cs_falls;
        wr(2'd2, 32'h11);
        repeat (20) @(negedge clk);
        check("R5 blocked by rx full", cs_falls - c0, 0);
        rd(2'd3, v); check("R3 rx word", v, 32'h3C);
        settle();
        check("R5 rx read releases", cs_falls - c0, 1);
        rd(2'd3, v); check("R5 second word", v, 32'h11);

        // R5 turbo lets a word start with rx full
        wr(2'd0, (32'd1 << 19) | (32'd7 << 7));
        wr(2'd2, 32'h22); settle();
        check("R10 turbo hides rx event", {31'd0, rx_evt}, 32'd0);
        c0 = cs_falls;
        wr(2'd2, 32'h33); settle();
        check("R5 turbo start", cs_falls - c0, 1);
        rd(2'd3, v); check("R5 turbo rx", v, 32'h33);

        // R6 transmit-only leaves rx-full clear
        wr(2'd0, (32'd2 << 12) | (32'd7 << 7));
        wr(2'd2, 32'h44); settle();
        rd(2'd1, v); check("R6 tx-only status", v, 32'hE);
        check("R10 tx-only events", {30'd0, tx_evt, rx_evt}, 32'h2);

        // R5/R9 receive-only: enable rise starts despite tx-empty
        wr(2'd0, (32'd1 << 15) | (32'd1 << 14) | (32'd1 << 12) | (32'd7 << 7));
        wr(2'd1, 32'd0);
        inv = 1'b1;
        c0 = cs_falls;
        wr(2'd1, 32'd1); settle();
        check("R5 rx-only start", cs_falls - c0, 1);
        check("R9 rx-only requests", {30'd0, dma_tx, dma_rx}, 32'h1);
        check("R10 rx-only events", {30'd0, tx_evt, rx_evt}, 32'h1);
        rd(2'd3, v); check("R7 inverted slave", v, 32'hFF);
        settle();
        check("R3 rx read restarts", cs_falls - c0, 2);
        wr(2'd1, 32'd0);
        rd(2'd3, v);
        inv = 1'b0;

        // R7 short field clamps to 4 bits
        wr(2'd0, 32'd1 << 7);
        wr(2'd1, 32'd1);
        r0 = rises;
        wr(2'd2, 32'hFB); settle();
        check("R7 clamp count", rises - r0, 4);
        rd(2'd3, v); check("R7 clamp rx", v, 32'hB);

        // R8 single-channel bypass without force
        single_mode = 1'b1;
        wr(2'd0, 32'd7 << 7);
        c0 = cs_falls; r0 = rises;
        wr(2'd2, 32'h5A);
        repeat (4) @(negedge clk);
        check("R8 no bus activity", (cs_falls - c0) + (rises - r0), 0);
        rd(2'd1, v); check("R8 status advances", v, 32'hF);
        rd(2'd3, v); check("R8 rx untouched", v, 32'hB);
        wr(2'd0, (32'd1 << 20) | (32'd7 << 7));
        wr(2'd2, 32'h5A); settle();
        rd(2'd3, v); check("R8 force shifts", v, 32'h5A);
        single_mode = 1'b0;

        // R9 transmit request by mode
        wr(2'd0, (32'd1 << 14) | (32'd7 << 7));
        @(negedge clk);
        check("R9 tx request", {31'd0, dma_tx}, 32'd1);
        wr(2'd0, (32'd1 << 14) | (32'd1 << 12) | (32'd7 << 7));
        @(negedge clk);
        check("R9 tx request rx-only", {31'd0, dma_tx}, 32'd0);

        // R7 random full-duplex words
        for (int i = 0; i < 40; i++) begin
            int fld;
            logic [31:0] d;
            fld = 3 + int'($urandom % 29);
            d   = $urandom;
            inv = $urandom % 2;
            wr(2'd0, 32'(fld) << 7);
            r0 = rises;
            wr(2'd2, d); settle();
            check("R7 random count", rises - r0, wlen(fld));
            check("R7 random mosi", cap & wmask(wlen(fld)), d & wmask(wlen(fld)));
            rd(2'd3, v); check("R7 random rx", v, exp_rx(d, fld, inv));
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule